// File: doc/BRIEF.md
# I2C Master Clock Generator with Stretch Timeout

This block produces the SCL clock of an I2C master. Two 8-bit period fields give the low phase and the high phase, each measured in system clocks. Values below a floor are raised to that floor. The block drives SCL open-drain. It pulls the line low for the low phase, then releases it. The high phase is counted only after the synchronized line has actually risen, so a slave that holds SCL low stretches the clock instead of shortening the high time.

A watchdog counts system clocks since the last start command or the last falling edge of the synchronized SCL. With a nonzero timeout setting, its limit is (setting + 1) whole bit periods. If the limit is reached while SCL is still low, a sticky flag is raised and the block stops driving the line until software clears the flag. A byte engine outside this block supplies the master-mode select, the busy indication and the start pulse. Software reaches the three registers through a small write/read port.

Top module: `i2c_scl_timer`

## Requirements
- R1: After reset the clock register (address 0) reads 0x0204, the timeout register (address 1) reads 0, the flag (address 2, bit 0) reads 0, and `scl_oe` is low.
- R2: The clock register holds the low field in bits 7:0 and the high field in bits 15:8. While the generator runs (master mode, busy, flag clear), each low phase asserts `scl_oe` for exactly max(low,4)+1 clocks.
- R3: After a low phase, `scl_oe` is released. The high phase of max(high,2)+1 clocks starts only once the synchronized SCL reads high. With a line that rises as soon as it is released, each released interval lasts max(high,2)+1+SYNC_STAGES+1 clocks.
- R4: Field values below the floors (2 high, 4 low) act as the floors, and reading the clock register returns the raw written value.
- R5: With timeout field T (address 1, bits 7:0) nonzero and SCL held low from before the start pulse, the flag is still clear on the clock edge (T+1)*(max(high,2)+max(low,4)+2) edges after the edge that samples start, and is set on the following edge.
- R6: The watchdog restarts on every SCL fall, so a normally toggling clock never raises the flag.
- R7: A timeout field of 0 disables the watchdog: SCL held low indefinitely never raises the flag.
- R8: With master mode deselected, `scl_oe` stays low from the next clock on and the flag is never raised.
- R9: Writes to the timeout register while `busy` is low are ignored.
- R10: The flag stays set until a write to address 2 with bit 0 set. Writing 0 there leaves it set. While the flag is set, `scl_oe` stays released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 clock, 1 timeout, 2 flag |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address (combinational read) |
| rd_data | output | 16 | Read data |
| master_en | input | 1 | Master mode select |
| busy | input | 1 | Transfer in progress indication |
| start | input | 1 | Start command pulse; restarts the watchdog |
| scl_in | input | 1 | Sampled SCL line (asynchronous) |
| scl_oe | output | 1 | Open-drain pull-low enable for SCL |
| timeout_flag | output | 1 | Sticky stretch-timeout flag |

## Verification
A register write takes effect on the edge that samples it and is read back combinationally half a cycle later. A low phase is seen on `scl_oe` the cycle after the state register enters it, and a released interval includes the synchronizer delay plus one decision cycle (three clocks by default). The flag becomes visible one edge after the watchdog count reaches its limit. The bench drives inputs and samples outputs on falling clock edges. It counts those edges exactly from the start pulse or from the phase boundary, and checks the flag both one edge before and on the edge where it must appear.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;

    localparam int FIELD_W = 8;
    localparam int REG_W   = 2 * FIELD_W;
    localparam int ADDR_W  = 2;
    localparam int SPAN_W  = FIELD_W + 2;
    localparam int LIM_W   = SPAN_W + FIELD_W + 1;

    localparam logic [ADDR_W-1:0] ADDR_CLK  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_TMO  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;

    typedef logic [FIELD_W-1:0] field_t;
    typedef logic [LIM_W-1:0]   limit_t;

    typedef struct packed {
        field_t hi;
        field_t lo;
    } clk_cfg_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOW,
        PH_WAIT,
        PH_HIGH
    } phase_e;

    function automatic field_t raise_to(field_t v, field_t floor_v);
        return (v < floor_v) ? floor_v : v;
    endfunction

    function automatic limit_t stretch_limit(field_t tmo, field_t hi, field_t lo);
        logic [SPAN_W-1:0]  span;
        logic [FIELD_W:0]   mult;
        span = SPAN_W'(hi) + SPAN_W'(lo) + SPAN_W'(2);
        mult = {1'b0, tmo} + 1'b1;
        return LIM_W'(span) * LIM_W'(mult);
    endfunction

endpackage

// File: rtl/i2c_scl_sync.sv
module i2c_scl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_scl_regs.sv
module i2c_scl_regs
    import i2c_scl_pkg::*;
#(
    parameter field_t HI_RESET = 8'd2,
    parameter field_t LO_RESET = 8'd4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              busy,
    input  logic              flag_set,
    output logic [REG_W-1:0]  rd_data,
    output clk_cfg_t          cfg,
    output field_t            tmo,
    output logic              flag
);
    logic wr_clk, wr_tmo, wr_clr;

    assign wr_clk = wr_en && (wr_addr == ADDR_CLK);
    assign wr_tmo = wr_en && (wr_addr == ADDR_TMO) && busy;
    assign wr_clr = wr_en && (wr_addr == ADDR_STAT) && wr_data[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.hi <= HI_RESET;
            cfg.lo <= LO_RESET;
        end else if (wr_clk) begin
            cfg <= clk_cfg_t'(wr_data);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         tmo <= '0;
        else if (wr_tmo) tmo <= wr_data[FIELD_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)           flag <= 1'b0;
        else if (flag_set) flag <= 1'b1;
        else if (wr_clr)   flag <= 1'b0;
    end

    always_comb begin
        unique case (rd_addr)
            ADDR_CLK:  rd_data = REG_W'(cfg);
            ADDR_TMO:  rd_data = REG_W'(tmo);
            ADDR_STAT: rd_data = REG_W'(flag);
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/i2c_scl_phase.sv
module i2c_scl_phase
    import i2c_scl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   run,
    input  logic   scl_s,
    input  field_t hi_len,
    input  field_t lo_len,
    output logic   scl_oe,
    output phase_e phase
);
    field_t cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    phase <= PH_LOW;
                    cnt   <= '0;
                end
                PH_LOW: begin
                    if (cnt == lo_len) begin
                        phase <= PH_WAIT;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_WAIT: begin
                    if (scl_s) begin
                        phase <= PH_HIGH;
                        cnt   <= '0;
                    end
                end
                PH_HIGH: begin
                    if (cnt == hi_len) begin
                        phase <= PH_LOW;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    phase <= PH_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    assign scl_oe = (phase == PH_LOW);
endmodule

// File: rtl/i2c_scl_watchdog.sv
module i2c_scl_watchdog
    import i2c_scl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   enable,
    input  logic   start,
    input  logic   scl_s,
    input  field_t tmo,
    input  field_t hi_len,
    input  field_t lo_len,
    output logic   expire
);
    limit_t limit;
    limit_t cnt;
    logic   scl_prev;
    logic   scl_fall;

    assign limit    = stretch_limit(tmo, hi_len, lo_len);
    assign scl_fall = scl_prev && !scl_s;

    always_ff @(posedge clk) begin
        if (rst) scl_prev <= 1'b0;
        else     scl_prev <= scl_s;
    end

    always_ff @(posedge clk) begin
        if (rst || !enable || start || scl_fall) cnt <= '0;
        else if (cnt != limit)                   cnt <= cnt + 1'b1;
    end

    assign expire = enable && (cnt == limit) && !scl_s;
endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
    import i2c_scl_pkg::*;
#(
    parameter int CKH_MIN     = 2,
    parameter int CKL_MIN     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [15:0] wr_data,
    input  logic [1:0]  rd_addr,
    output logic [15:0] rd_data,
    input  logic        master_en,
    input  logic        busy,
    input  logic        start,
    input  logic        scl_in,
    output logic        scl_oe,
    output logic        timeout_flag
);
    localparam field_t HI_FLOOR = field_t'(CKH_MIN);
    localparam field_t LO_FLOOR = field_t'(CKL_MIN);

    clk_cfg_t cfg_q;
    field_t   to_q;
    field_t   hi_eff;
    field_t   lo_eff;
    logic     scl_s;
    logic     gen_run;
    logic     wd_en;
    logic     wd_expire;
    phase_e   phase_q;

    assign hi_eff  = raise_to(cfg_q.hi, HI_FLOOR);
    assign lo_eff  = raise_to(cfg_q.lo, LO_FLOOR);
    assign gen_run = master_en && busy && !timeout_flag;
    assign wd_en   = gen_run && (to_q != '0);

    i2c_scl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (scl_in),
        .q   (scl_s)
    );

    i2c_scl_regs #(.HI_RESET(HI_FLOOR), .LO_RESET(LO_FLOOR)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .busy     (busy),
        .flag_set (wd_expire),
        .rd_data  (rd_data),
        .cfg      (cfg_q),
        .tmo      (to_q),
        .flag     (timeout_flag)
    );

    i2c_scl_phase u_phase (
        .clk    (clk),
        .rst    (rst),
        .run    (gen_run),
        .scl_s  (scl_s),
        .hi_len (hi_eff),
        .lo_len (lo_eff),
        .scl_oe (scl_oe),
        .phase  (phase_q)
    );

    i2c_scl_watchdog u_wd (
        .clk    (clk),
        .rst    (rst),
        .enable (wd_en),
        .start  (start),
        .scl_s  (scl_s),
        .tmo    (to_q),
        .hi_len (hi_eff),
        .lo_len (lo_eff),
        .expire (wd_expire)
    );
endmodule

// File: rtl/i2c_scl_timer_chk.sv
module i2c_scl_timer_chk
    import i2c_scl_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        master_en,
    input logic        busy,
    input logic        wr_en,
    input logic [1:0]  wr_addr,
    input logic [15:0] wr_data,
    input logic        scl_oe,
    input logic        timeout_flag,
    input field_t      to_val,
    input field_t      lo_len
);
    logic [FIELD_W+1:0] low_run;

    always_ff @(posedge clk) begin
        if (rst)         low_run <= '0;
        else if (scl_oe) low_run <= low_run + 1'b1;
        else             low_run <= '0;
    end

    assert_low_bounded_R2: assert property (@(posedge clk) disable iff (rst)
        scl_oe |-> (low_run <= (FIELD_W+2)'(lo_len)));

    assert_released_off_R8: assert property (@(posedge clk) disable iff (rst)
        !master_en |=> !scl_oe);

    assert_no_flag_rise_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout_flag) |-> $past(master_en));

    assert_to_write_gated_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_TMO && !busy) |=> $stable(to_val));

    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (timeout_flag && !(wr_en && wr_addr == ADDR_STAT && wr_data[0])) |=> timeout_flag);

    assert_flag_releases_R10: assert property (@(posedge clk) disable iff (rst)
        timeout_flag |=> !scl_oe);
endmodule

bind i2c_scl_timer i2c_scl_timer_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .master_en    (master_en),
    .busy         (busy),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .scl_oe       (scl_oe),
    .timeout_flag (timeout_flag),
    .to_val       (to_q),
    .lo_len       (lo_eff)
);

// File: tb/i2c_scl_timer_test.sv
`timescale 1ns/1ps
module i2c_scl_timer_test;
    localparam int SYNC = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        master_en = 1'b0;
    logic        busy = 1'b0;
    logic        start = 1'b0;
    logic        hold_low = 1'b0;
    logic        scl_in;
    logic        scl_oe;
    logic        timeout_flag;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    assign scl_in = !(scl_oe || hold_low);

    i2c_scl_timer #(.SYNC_STAGES(SYNC)) uut (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .master_en    (master_en),
        .busy         (busy),
        .start        (start),
        .scl_in       (scl_in),
        .scl_oe       (scl_oe),
        .timeout_flag (timeout_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic measure(output int lo, output int hi);
        while (scl_oe) @(negedge clk);
        while (!scl_oe) @(negedge clk);
        lo = 0;
        while (scl_oe) begin lo++; @(negedge clk); end
        hi = 0;
        while (!scl_oe) begin hi++; @(negedge clk); end
    endtask

    function automatic int floor_of(input int v, input int f);
        return (v < f) ? f : v;
    endfunction

    task automatic stretch_case(input int h, input int l, input int t);
        int lim, v;
        lim = (t + 1) * (floor_of(h, 2) + floor_of(l, 4) + 2);
        master_en = 1'b0; busy = 1'b1;
        reg_wr(2'd0, 16'((h << 8) | l));
        reg_wr(2'd1, 16'(t));
        reg_rd(2'd1, v);
        chk("R5 timeout readback", v, t);
        hold_low = 1'b1;
        repeat (4) @(negedge clk);
        master_en = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (lim) @(negedge clk);
        chk("R5 flag one edge early", int'(timeout_flag), 0);
        @(negedge clk);
        chk("R5 flag on limit edge", int'(timeout_flag), 1);
        master_en = 1'b0;
        hold_low = 1'b0;
        reg_wr(2'd2, 16'h0001);
        busy = 1'b0;
        @(negedge clk);
    endtask

    task automatic report;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            report();
            $finish;
        end
    end

    initial begin
        int v, lo, hi, oe_seen;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        reg_rd(2'd0, v); chk("R1 clock reg", v, 16'h0204);
        reg_rd(2'd1, v); chk("R1 timeout reg", v, 0);
        reg_rd(2'd2, v); chk("R1 flag reg", v, 0);
        chk("R1 scl_oe", int'(scl_oe), 0);
        chk("R1 timeout_flag", int'(timeout_flag), 0);

        // R2 R3 R4 sweep of both fields, including values under the floors
        foreach (hv_list[i]) begin end
        for (int hi_i = 0; hi_i < 5; hi_i++) begin
            for (int lo_i = 0; lo_i < 5; lo_i++) begin
                int h, l;
                h = (hi_i == 4) ? 7 : hi_i;
                l = (lo_i == 4) ? 9 : lo_i + 2;
                master_en = 1'b0; busy = 1'b0;
                reg_wr(2'd0, 16'((h << 8) | l));
                reg_rd(2'd0, v);
                chk("R4 raw readback", v, (h << 8) | l);
                master_en = 1'b1; busy = 1'b1;
                measure(lo, hi);
                measure(lo, hi);
                chk("R2 low phase length", lo, floor_of(l, 4) + 1);
                chk("R3 released length", hi, floor_of(h, 2) + 1 + SYNC + 1);
                busy = 1'b0;
                @(negedge clk);
            end
        end

        // R5 stretch timeout exact edge, several settings
        stretch_case(0, 0, 1);
        stretch_case(0, 0, 2);
        stretch_case(3, 6, 1);
        stretch_case(3, 6, 5);
        stretch_case(1, 9, 3);

        // R9 timeout write ignored while busy low (current value 3)
        busy = 1'b0;
        reg_wr(2'd1, 16'd9);
        reg_rd(2'd1, v);
        chk("R9 write ignored", v, 3);
        busy = 1'b1;
        reg_wr(2'd1, 16'd1);
        reg_rd(2'd1, v);
        chk("R9 write accepted when busy", v, 1);

        // R6 toggling clock with smallest timeout never expires
        reg_wr(2'd0, 16'h0000);
        master_en = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (600) @(negedge clk);
        chk("R6 no timeout while toggling", int'(timeout_flag), 0);
        master_en = 1'b0;
        @(negedge clk);

        // R8 master mode off: no drive, no timeout
        hold_low = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        oe_seen = 0;
        for (int k = 0; k < 500; k++) begin
            if (scl_oe) oe_seen++;
            @(negedge clk);
        end
        chk("R8 scl_oe idle", oe_seen, 0);
        chk("R8 no flag", int'(timeout_flag), 0);

        // R7 zero timeout disables watchdog
        reg_wr(2'd1, 16'd0);
        master_en = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3000) @(negedge clk);
        chk("R7 no flag when disabled", int'(timeout_flag), 0);
        master_en = 1'b0;
        @(negedge clk);

        // R10 sticky flag, release of SCL, write-one-to-clear
        reg_wr(2'd1, 16'd1);
        master_en = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (40) @(negedge clk);
        chk("R10 flag set", int'(timeout_flag), 1);
        hold_low = 1'b0;
        @(negedge clk);
        oe_seen = 0;
        for (int k = 0; k < 60; k++) begin
            if (scl_oe) oe_seen++;
            @(negedge clk);
        end
        chk("R10 scl released while flagged", oe_seen, 0);
        chk("R10 flag still set", int'(timeout_flag), 1);
        reg_wr(2'd2, 16'h0000);
        reg_rd(2'd2, v);
        chk("R10 write zero keeps flag", v, 1);
        master_en = 1'b0;
        reg_wr(2'd2, 16'h0001);
        reg_rd(2'd2, v);
        chk("R10 write one clears flag", v, 0);
        master_en = 1'b1;
        measure(lo, hi);
        chk("R10 clock resumes after clear", lo, 5);
        master_en = 1'b0; busy = 1'b0;
        @(negedge clk);

        done = 1'b1;
        report();
        $finish;
    end

    int hv_list[1] = '{0};
endmodule